// File: doc/BRIEF.md
# Clock Control Register with Source Interlocks

This block is the byte-wide control register of a microcontroller clock generator, together with the glitch-free switch that it steers. Software writes it over a simple register bus (a write strobe, an address-match qualifier and a data byte) and reads it back at any time. The register holds a PLL run enable, a two-bit PLL multiplication code, a system clock source select and a two-bit peripheral divider code.

The block enforces the rules that keep the clock tree safe. The multiplication code may be changed once per reset, and only while the oscillator input is the system clock. The PLL source cannot be selected while the PLL is off. Turning the PLL off drops the selection back to the oscillator in the same write. A stop-mode input forces the PLL off without touching the stored bits.

The system clock is taken from either the oscillator input or the PLL output. The hand-over between them goes through a break-before-make switch with a synchronizer chain in each clock domain. The PLL path is taken only once the external lock indication is high.

Top module: `ccr_clock_ctrl`

## Requirements
- R1: After reset the read value is 0x06: PLL enable (bit 1) is 1, the ratio code (bits 3:2) is 01, source select (bit 5) is 0 and divider code (bits 7:6) is 00. Also after reset, pll_run is 1, pll_ratio is 01 and div_sel is 00.
- R2: The ratio code on pll_ratio is 01 for x2, 10 for x3 and 11 for x4. A write carrying 00 in bits 3:2 leaves the code unchanged and does not use up the one permitted change.
- R3: After reset, only the first accepted ratio write changes bits 3:2. Every later ratio write is ignored until the next reset.
- R4: A ratio write made while bit 5 reads 1 is dropped, and the one permitted change is still available afterwards.
- R5: Bit 5 becomes 1 only when the write carries 1 in both bit 5 and bit 1 and bit 1 already reads 1 before the write. Otherwise a 1 written to bit 5 is ignored.
- R6: A write that clears bit 1 also clears bit 5 in that same write.
- R7: While stop_req is high, pll_run is 0 whatever bit 1 holds, and the stored register bits do not change.
- R8: Bits 0 and 4 always read 0, and writes to them have no effect.
- R9: Bits 7:6 take the written value on every accepted write and drive div_sel.
- R10: A write takes effect only on a clock edge where wr_en and addr_hit are both high. With either one low, the read value stays the same.
- R11: sys_clk follows xin_clk unless bit 5 is 1, pll_run is 1 and pll_lock is high. In that case it follows pll_clk. Moving from one source to the other never passes through both at once.
- R12: pll_run is high exactly when bit 1 is 1 and stop_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr_hit | input | 1 | Address decode match for this register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Register read value |
| stop_req | input | 1 | Stop mode: forces the PLL inactive |
| xin_clk | input | 1 | Oscillator input clock |
| pll_clk | input | 1 | PLL output clock |
| pll_lock | input | 1 | PLL lock indication |
| pll_run | output | 1 | PLL run enable to the analog PLL |
| pll_ratio | output | 2 | Multiplication code to the analog PLL |
| div_sel | output | 2 | Peripheral clock divider code |
| sys_clk | output | 1 | Selected system clock |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. The longer hand-over latency then shows up in the switch tests, and edge counting over a settled window still tells the oscillator rate from the PLL rate. With the oscillator at a period of 26 ns and the PLL at 8 ns, the two sources give clearly separate edge counts. This lets the bench confirm that the lock gate holds the oscillator in place, and that stop mode returns the system clock to the oscillator. The register vectors are ordered so that reserved and blocked ratio writes come before the single accepted one, which shows that the permission survives them.

// File: rtl/ccr_pkg.sv
// Package: field positions, reset values and the state record of the clock
// control register. Assumes an 8-bit register with the layout below.
package ccr_pkg;
    localparam int REG_W     = 8;
    localparam int EN_BIT    = 1;
    localparam int RATIO_LO  = 2;
    localparam int RATIO_W   = 2;
    localparam int SRC_BIT   = 5;
    localparam int DIV_LO    = 6;
    localparam int DIV_W     = 2;

    localparam logic [RATIO_W-1:0] RATIO_RST      = 2'b01;
    localparam logic [RATIO_W-1:0] RATIO_RESERVED = 2'b00;

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic               src;
        logic [RATIO_W-1:0] ratio;
        logic               en;
    } ccr_state_t;

    localparam ccr_state_t STATE_RST = '{div: '0, src: 1'b0, ratio: RATIO_RST, en: 1'b1};
endpackage

// File: rtl/ccr_sync.sv
// Module: multi-stage synchronizer clocked on the falling edge of its clock,
// so the enable it produces only changes while that clock is low.
// Assumes STAGES >= 2; reset is synchronous to the destination clock.
module ccr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the chain on each falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ccr_glitchfree_mux.sv
// Module: break-before-make clock switch between two sources. Each source
// has its own synchronizer chain, which is enabled only once the other
// source's enable has dropped. Assumes both clocks keep running during a switch.
module ccr_glitchfree_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic rst_n,
    input  logic xin_clk,
    input  logic pll_clk,
    input  logic want_pll,
    output logic sys_clk
);
    logic xin_en;
    logic pll_en;
    logic xin_req;
    logic pll_req;

    // Cross-coupled requests: a source may turn on only when the other is off.
    always_comb begin
        xin_req = !want_pll && !pll_en;
        pll_req =  want_pll && !xin_en;
    end

    ccr_sync #(.STAGES(SYNC_STAGES)) u_sync_xin (
        .clk(xin_clk), .rst_n(rst_n), .d(xin_req), .q(xin_en)
    );

    ccr_sync #(.STAGES(SYNC_STAGES)) u_sync_pll (
        .clk(pll_clk), .rst_n(rst_n), .d(pll_req), .q(pll_en)
    );

    // Gate each source with its low-phase-updated enable and merge.
    assign sys_clk = (xin_clk & xin_en) | (pll_clk & pll_en);
endmodule

// File: rtl/ccr_regs.sv
// Module: register storage and write interlocks. The ratio code may change
// once per reset, only while the oscillator is selected and never to the
// reserved code. The source select needs the enable both before and in the
// write. Assumes a single-cycle write strobe qualified by an address match.
module ccr_regs
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic [REG_W-1:0] wr_data,
    output ccr_state_t       state
);
    logic ratio_spent;
    logic ratio_ok;
    logic [RATIO_W-1:0] new_ratio;

    // Decide whether this write may change the ratio code.
    always_comb begin
        new_ratio = wr_data[RATIO_LO +: RATIO_W];
        ratio_ok  = !ratio_spent && !state.src && (new_ratio != RATIO_RESERVED);
    end

    // Update the fields on an accepted write, applying the interlocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= STATE_RST;
            ratio_spent <= 1'b0;
        end else if (wr_go) begin
            state.en  <= wr_data[EN_BIT];
            state.div <= wr_data[DIV_LO +: DIV_W];
            state.src <= wr_data[SRC_BIT] && wr_data[EN_BIT] && state.en;
            if (ratio_ok) begin
                state.ratio <= new_ratio;
                ratio_spent <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccr_clock_ctrl.sv
// Module: top of the clock control register. Holds the fields, forms the
// read value, applies stop mode to the PLL run output and steers the
// glitch-free system clock switch. Assumes pll_lock is meaningful only
// while pll_run is high.
module ccr_clock_ctrl
    import ccr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr_hit,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             stop_req,
    input  logic             xin_clk,
    input  logic             pll_clk,
    input  logic             pll_lock,
    output logic             pll_run,
    output logic [RATIO_W-1:0] pll_ratio,
    output logic [DIV_W-1:0] div_sel,
    output logic             sys_clk
);
    ccr_state_t st;
    logic       want_pll;

    ccr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_en && addr_hit),
        .wr_data(wr_data), .state(st)
    );

    // Build the read value; unused bits read zero.
    always_comb begin
        rd_data = '0;
        rd_data[EN_BIT]                = st.en;
        rd_data[RATIO_LO +: RATIO_W]   = st.ratio;
        rd_data[SRC_BIT]               = st.src;
        rd_data[DIV_LO +: DIV_W]       = st.div;
    end

    // Drive the PLL controls and the clock switch request.
    always_comb begin
        pll_run   = st.en && !stop_req;
        pll_ratio = st.ratio;
        div_sel   = st.div;
        want_pll  = st.src && pll_run && pll_lock;
    end

    ccr_glitchfree_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .rst_n(rst_n), .xin_clk(xin_clk), .pll_clk(pll_clk),
        .want_pll(want_pll), .sys_clk(sys_clk)
    );
endmodule

// File: rtl/ccr_clock_ctrl_chk.sv
// Module: assertion checker bound to the clock control register top.
// Observes ports only, in the register bus clock domain.
module ccr_clock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       addr_hit,
    input logic [7:0] rd_data,
    input logic       stop_req,
    input logic       pll_run,
    input logic [1:0] pll_ratio
);
    logic [1:0] ratio_changes;

    // Count ratio code changes since reset (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_changes <= '0;
        else if (pll_ratio != rd_data[3:2] || ratio_changes == 2'd3)
            ratio_changes <= ratio_changes;
        else if ($past(rst_n) && pll_ratio != $past(pll_ratio))
            ratio_changes <= ratio_changes + 2'd1;
    end

    // R3: the code changes at most once per reset.
    always_ff @(posedge clk) begin
        if (rst_n) a_r3_ratio_once: assert (ratio_changes <= 2'd1);
    end

    a_r2_ratio_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ratio != 2'b00);

    a_r5_src_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] |-> rd_data[1]);

    a_r5_src_rise_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[5]) |-> $past(rd_data[1]));

    a_r6_clear_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[1]) |-> !rd_data[5]);

    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] && !rd_data[4]);

    a_r10_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_hit) |=> $stable(rd_data));

    a_r12_run_rule: assert property (@(posedge clk) disable iff (!rst_n)
        pll_run |-> (rd_data[1] && !stop_req));

    a_r7_stop_kills_run: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> !pll_run);
endmodule

bind ccr_clock_ctrl ccr_clock_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hit(addr_hit),
    .rd_data(rd_data), .stop_req(stop_req), .pll_run(pll_run),
    .pll_ratio(pll_ratio)
);

// File: tb/ccr_clock_ctrl_tb.sv
module ccr_clock_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int XIN_PERIOD = 26;
    localparam int PLL_PERIOD = 8;
    localparam int NVEC = 10;

    // {wr_en, addr_hit, data, expected read}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hFF, 8'h06},  // R10 no address match
        {1'b0, 1'b1, 8'hFF, 8'h06},  // R10 no strobe
        {1'b1, 1'b1, 8'h22, 8'h26},  // R5 src set, R2 reserved ratio dropped
        {1'b1, 1'b1, 8'h2E, 8'h26},  // R4 ratio dropped while src=1
        {1'b1, 1'b1, 8'hC2, 8'hC6},  // R9 divider
        {1'b1, 1'b1, 8'h19, 8'h08},  // R8 unused bits, R4 permission kept
        {1'b1, 1'b1, 8'h2A, 8'h0A},  // R5 src blocked while en was 0, R3
        {1'b1, 1'b1, 8'h2E, 8'h2A},  // R3 later ratio write ignored
        {1'b1, 1'b1, 8'h20, 8'h08},  // R6 clearing en clears src
        {1'b1, 1'b1, 8'h62, 8'h4A}   // R9 divider 01
    };

    logic clk = 0, xin_clk = 0, pll_clk = 0;
    logic rst_n = 0, wr_en = 0, addr_hit = 0, stop_req = 0, pll_lock = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic pll_run, sys_clk;
    logic [1:0] pll_ratio, div_sel;

    int checks = 0, errors = 0;
    int edges = 0;
    logic counting = 0;
    logic done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(XIN_PERIOD/2) xin_clk = ~xin_clk;
    always #(PLL_PERIOD/2) pll_clk = ~pll_clk;

    always @(posedge sys_clk) if (counting) edges++;

    ccr_clock_ctrl #(.SYNC_STAGES(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_hit(addr_hit),
        .wr_data(wr_data), .rd_data(rd_data), .stop_req(stop_req),
        .xin_clk(xin_clk), .pll_clk(pll_clk), .pll_lock(pll_lock),
        .pll_run(pll_run), .pll_ratio(pll_ratio), .div_sel(div_sel),
        .sys_clk(sys_clk)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        wr_en = 0; addr_hit = 0;
        repeat (20) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic bus(input logic we, input logic hit, input logic [7:0] d);
        @(negedge clk);
        wr_en = we; addr_hit = hit; wr_data = d;
        @(negedge clk);
        wr_en = 0; addr_hit = 0;
    endtask

    task automatic count_edges(output int n);
        #200;
        edges = 0;
        counting = 1;
        #2000;
        counting = 0;
        n = edges;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h06);
        check("R1 pll_run", pll_run, 1);
        check("R1 pll_ratio", pll_ratio, 2'b01);
        check("R1 div_sel", div_sel, 2'b00);

        for (int i = 0; i < NVEC; i++) begin
            bus(VEC[i][17], VEC[i][16], VEC[i][15:8]);
            check($sformatf("vector %0d", i), rd_data, VEC[i][7:0]);
        end
        check("R3 pll_ratio after once", pll_ratio, 2'b10);
        check("R9 div_sel", div_sel, 2'b01);
        check("R12 pll_run en=1", pll_run, 1);

        // R7 stop mode
        @(negedge clk); stop_req = 1;
        @(negedge clk);
        check("R7 pll_run in stop", pll_run, 0);
        check("R7 rd_data kept", rd_data, 8'h4A);
        @(negedge clk); stop_req = 0;
        @(negedge clk);
        check("R12 pll_run after stop", pll_run, 1);

        // R2 ratio x4 code after fresh reset, then clock switching
        do_reset();
        bus(1, 1, 8'h0E);
        check("R2 x4 code", pll_ratio, 2'b11);
        count_edges(n);
        check("R11 xin at reset", int'(n >= 70 && n <= 80), 1);
        bus(1, 1, 8'h22);
        check("R5 src set", rd_data, 8'h2E);
        count_edges(n);
        check("R11 no lock keeps xin", int'(n >= 70 && n <= 80), 1);
        pll_lock = 1;
        count_edges(n);
        check("R11 pll after lock", int'(n >= 240 && n <= 255), 1);
        stop_req = 1;
        count_edges(n);
        check("R11 stop returns xin", int'(n >= 70 && n <= 80), 1);
        stop_req = 0;
        count_edges(n);
        check("R11 back to pll", int'(n >= 240 && n <= 255), 1);
        bus(1, 1, 8'h00);
        check("R6 en clear", rd_data, 8'h0C);
        count_edges(n);
        check("R11 en off gives xin", int'(n >= 70 && n <= 80), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule